// File: doc/BRIEF.md
# Jump Condition and Target Evaluator

This block is the branch decision stage of a small virtual-machine core. It receives one decoded jump-family instruction per clock: the 8-bit opcode, the instruction's source-register field, the destination and source register values, the 32-bit immediate, the signed 16-bit offset and the index of the current instruction. From these it decides whether the jump is taken and which instruction slot comes next. Call and return instructions are not executed here. They are only flagged so that a separate control unit can handle the stack and the dispatch.

The opcode carries a 3-bit class in its low bits, a source-select bit at bit 3 and a 4-bit condition code in its high nibble. Two classes are jump classes. Class 5 compares full-width operands and class 6 compares only their low halves. Every result is registered, so a decision appears one clock after its instruction is presented. A new instruction can be presented on every clock.

Top module: `br_eval`

## Requirements
- R1: Class 5 (opcode bits 2:0 = 5) compares all 64 operand bits. Class 6 compares only bits 31:0, so differences in the upper half do not change the outcome.
- R2: Opcode bit 3 = 1 selects the source register value as the second operand. Bit 3 = 0 selects the 32-bit immediate, sign-extended to 64 bits.
- R3: The unsigned relations are greater-than (code 0x2), greater-or-equal (0x3), less-than (0xa) and less-or-equal (0xb). Each is taken when the relation holds between the destination and the second operand.
- R4: The signed two's-complement relations are greater-than (0x6), greater-or-equal (0x7), less-than (0xc) and less-or-equal (0xd). Each uses the sign bit of the compared width, so opcode 0x7e is a 32-bit signed greater-or-equal against a register.
- R5: Code 0x1 is taken on equality and code 0x5 on inequality. Code 0x4 is taken when the bitwise AND of the two operands is nonzero.
- R6: A taken jump yields next_pc = pc + 1 + sign-extended offset. Any instruction that does not jump yields next_pc = pc + 1. Both wrap modulo 2^PC_W.
- R7: Code 0x0 in class 5 is an unconditional jump that is always taken, whatever the operand values.
- R8: Code 0x8 in class 5 raises is_call. Source field 1 (a local function) is taken to pc + 1 + offset. Source fields 0 and 2 (helper calls) are not taken. Any other source field is illegal.
- R9: Code 0x9 in class 5 raises is_exit and is never taken.
- R10: The following raise illegal: codes 0x0, 0x8 or 0x9 in class 6; codes 0xe and 0xf in any class; any class other than 5 or 6. An illegal instruction is never taken, never raises is_call or is_exit, and yields next_pc = pc + 1.
- R11: All outputs are registered with one clock of latency. A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 8 | Instruction opcode |
| src_sel_i | input | 4 | Source-register field of the instruction (selects the call kind) |
| dst_val_i | input | DATA_W | Destination register value |
| src_val_i | input | DATA_W | Source register value |
| imm_i | input | IMM_W | Immediate field |
| offset_i | input | OFF_W | Signed jump offset |
| pc_i | input | PC_W | Index of the current instruction |
| taken_o | output | 1 | Jump is taken |
| next_pc_o | output | PC_W | Index of the next instruction |
| is_call_o | output | 1 | Instruction is a call |
| is_exit_o | output | 1 | Instruction is a return |
| illegal_o | output | 1 | Encoding is not valid |

## Verification
Every output is due exactly one rising edge after its instruction is presented. No result takes more or fewer than that one register stage. The bench drives each instruction on a falling edge and holds it across one rising edge. It then compares all five outputs with a behavioural model on the next falling edge, before the following instruction can influence them. One check samples just after the inputs change, before any rising edge, to confirm that the previous result is still held.

// File: rtl/br_pkg.sv
package br_pkg;

    // Instruction class values held in opcode bits 2:0
    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    // Operation codes held in opcode bits 7:4
    typedef enum logic [3:0] {
        OP_ALWAYS = 4'h0,
        OP_EQ     = 4'h1,
        OP_UGT    = 4'h2,
        OP_UGE    = 4'h3,
        OP_ANY    = 4'h4,
        OP_NE     = 4'h5,
        OP_SGT    = 4'h6,
        OP_SGE    = 4'h7,
        OP_CALL   = 4'h8,
        OP_RET    = 4'h9,
        OP_ULT    = 4'ha,
        OP_ULE    = 4'hb,
        OP_SLT    = 4'hc,
        OP_SLE    = 4'hd,
        OP_RSV_E  = 4'he,
        OP_RSV_F  = 4'hf
    } br_op_e;

    // Call kinds taken from the source-register field
    localparam logic [3:0] CALL_HELPER_ADDR = 4'd0;
    localparam logic [3:0] CALL_LOCAL       = 4'd1;
    localparam logic [3:0] CALL_HELPER_TYPE = 4'd2;

    typedef struct packed {
        logic   legal;
        logic   is_cond;
        logic   is_always;
        logic   is_call;
        logic   call_local;
        logic   is_ret;
        logic   wide;
        logic   use_reg;
        br_op_e op;
    } br_dec_t;

    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic any;
    } br_rel_t;

    // Picks the relation named by op out of the primitive flags
    function automatic logic rel_pick(br_op_e op, br_rel_t r);
        logic res;
        unique case (op)
            OP_EQ:   res = r.eq;
            OP_NE:   res = !r.eq;
            OP_UGT:  res = !r.ult && !r.eq;
            OP_UGE:  res = !r.ult;
            OP_ULT:  res = r.ult;
            OP_ULE:  res = r.ult || r.eq;
            OP_SGT:  res = !r.slt && !r.eq;
            OP_SGE:  res = !r.slt;
            OP_SLT:  res = r.slt;
            OP_SLE:  res = r.slt || r.eq;
            OP_ANY:  res = r.any;
            default: res = 1'b0;
        endcase
        return res;
    endfunction

    function automatic logic op_is_relation(br_op_e op);
        return (op inside {OP_EQ, OP_UGT, OP_UGE, OP_ANY, OP_NE, OP_SGT,
                           OP_SGE, OP_ULT, OP_ULE, OP_SLT, OP_SLE});
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    opcode,
    input  logic [3:0]    src_sel,
    output br_dec_t       dec
);
    logic [2:0] cls;
    br_op_e     op;
    logic       cls_w;
    logic       cls_n;

    assign cls   = opcode[2:0];
    assign op    = br_op_e'(opcode[7:4]);
    assign cls_w = (cls == CLS_WIDE);
    assign cls_n = (cls == CLS_NARROW);

    always_comb begin
        dec            = '0;
        dec.op         = op;
        dec.wide       = cls_w;
        dec.use_reg    = opcode[3];
        if (op_is_relation(op)) begin
            dec.legal   = cls_w || cls_n;
            dec.is_cond = cls_w || cls_n;
        end else if (op == OP_ALWAYS) begin
            dec.legal     = cls_w;
            dec.is_always = cls_w;
        end else if (op == OP_CALL) begin
            if (cls_w && (src_sel == CALL_HELPER_ADDR || src_sel == CALL_LOCAL ||
                          src_sel == CALL_HELPER_TYPE)) begin
                dec.legal      = 1'b1;
                dec.is_call    = 1'b1;
                dec.call_local = (src_sel == CALL_LOCAL);
            end
        end else if (op == OP_RET) begin
            dec.legal  = cls_w;
            dec.is_ret = cls_w;
        end
    end

    // R10: a legal instruction belongs to exactly one kind, an illegal one to none
    assert_single_kind_R10: assert property (@(posedge clk) disable iff (rst)
        dec.legal |-> ($countones({dec.is_cond, dec.is_always, dec.is_call, dec.is_ret}) == 1));

    assert_no_kind_when_bad_R10: assert property (@(posedge clk) disable iff (rst)
        !dec.legal |-> ({dec.is_cond, dec.is_always, dec.is_call, dec.is_ret} == 4'b0000));

    // R10: the narrow class has no unconditional jump, call or return
    assert_narrow_restrict_R10: assert property (@(posedge clk) disable iff (rst)
        (opcode[2:0] == CLS_NARROW && opcode[7:4] inside {4'h0, 4'h8, 4'h9}) |-> !dec.legal);

endmodule

// File: rtl/br_compare.sv
module br_compare
    import br_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    input  br_dec_t           dec,
    output logic              hit
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] a_u;
    logic [DATA_W-1:0] b_u;
    logic              a_neg;
    logic              b_neg;
    br_rel_t           rel;

    generate
        if (EXT_W > 0) begin : g_sext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_plain
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    assign opnd_b = dec.use_reg ? src_val : imm_ext;

    // Narrow comparisons see zero-extended low halves and the half-width sign bit
    always_comb begin
        if (dec.wide) begin
            a_u   = dst_val;
            b_u   = opnd_b;
            a_neg = dst_val[DATA_W-1];
            b_neg = opnd_b[DATA_W-1];
        end else begin
            a_u   = {{(DATA_W-HALF_W){1'b0}}, dst_val[HALF_W-1:0]};
            b_u   = {{(DATA_W-HALF_W){1'b0}}, opnd_b[HALF_W-1:0]};
            a_neg = dst_val[HALF_W-1];
            b_neg = opnd_b[HALF_W-1];
        end
    end

    always_comb begin
        rel.eq  = (a_u == b_u);
        rel.ult = (a_u < b_u);
        rel.slt = (a_neg != b_neg) ? a_neg : (a_u < b_u);
        rel.any = |(a_u & b_u);
    end

    assign hit = dec.is_cond && rel_pick(dec.op, rel);

    // R5: equality and inequality never both hit on the same operands
    assert_eq_excl_R5: assert property (@(posedge clk) disable iff (rst)
        (dec.is_cond && dec.op == OP_EQ && hit) |-> (rel.eq && !rel.ult));

    // R3: unsigned less-than implies the operands differ
    assert_ult_ne_R3: assert property (@(posedge clk) disable iff (rst)
        rel.ult |-> !rel.eq);

endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             jump,
    output logic [PC_W-1:0]  next_pc
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] step;

    generate
        if (EXT_W > 0) begin : g_sext
            assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[PC_W-1:0];
        end
    endgenerate

    assign step    = jump ? off_ext : '0;
    assign next_pc = pc + PC_W'(1) + step;

endmodule

// File: rtl/br_eval.sv
module br_eval
    import br_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        opcode_i,
    input  logic [3:0]        src_sel_i,
    input  logic [DATA_W-1:0] dst_val_i,
    input  logic [DATA_W-1:0] src_val_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              is_call_o,
    output logic              is_exit_o,
    output logic              illegal_o
);
    br_dec_t         dec;
    logic            hit;
    logic            jump;
    logic [PC_W-1:0] nxt;
    logic            primed_q;

    br_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode_i),
        .src_sel (src_sel_i),
        .dec     (dec)
    );

    br_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_compare (
        .clk     (clk),
        .rst     (rst),
        .dst_val (dst_val_i),
        .src_val (src_val_i),
        .imm     (imm_i),
        .dec     (dec),
        .hit     (hit)
    );

    assign jump = dec.legal && (dec.is_always || hit || (dec.is_call && dec.call_local));

    br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc      (pc_i),
        .offset  (offset_i),
        .jump    (jump),
        .next_pc (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            is_call_o <= 1'b0;
            is_exit_o <= 1'b0;
            illegal_o <= 1'b0;
            primed_q  <= 1'b0;
        end else begin
            taken_o   <= jump;
            next_pc_o <= nxt;
            is_call_o <= dec.is_call;
            is_exit_o <= dec.is_ret;
            illegal_o <= !dec.legal;
            primed_q  <= 1'b1;
        end
    end

    // R10: an illegal result carries no action
    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (rst || !primed_q)
        illegal_o |-> (!taken_o && !is_call_o && !is_exit_o));

    // R6: a result that does not jump points at the following slot
    assert_fallthrough_R6: assert property (@(posedge clk) disable iff (rst || !primed_q)
        !taken_o |-> (next_pc_o == $past(pc_i) + PC_W'(1)));

    // R9: a return never jumps
    assert_exit_no_jump_R9: assert property (@(posedge clk) disable iff (rst || !primed_q)
        is_exit_o |-> !taken_o);

    // R7: the wide unconditional jump is always taken
    assert_always_taken_R7: assert property (@(posedge clk) disable iff (rst || !primed_q)
        ($past(opcode_i) == 8'h05) |-> taken_o);

    // R8: only the local call kind jumps
    assert_call_kind_R8: assert property (@(posedge clk) disable iff (rst || !primed_q)
        is_call_o |-> (taken_o == ($past(src_sel_i) == 4'd1)));

    // R11: reset leaves every output cleared
    assert_reset_clear_R11: assert property (@(posedge clk)
        $past(rst) |-> ({taken_o, is_call_o, is_exit_o, illegal_o} == 4'b0 && next_pc_o == '0));

endmodule

// File: tb/br_eval_tb.sv
module br_eval_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode_i = '0;
    logic [3:0]  src_sel_i = '0;
    logic [63:0] dst_val_i = '0;
    logic [63:0] src_val_i = '0;
    logic [31:0] imm_i = '0;
    logic [15:0] offset_i = '0;
    logic [31:0] pc_i = '0;
    logic        taken_o;
    logic [31:0] next_pc_o;
    logic        is_call_o;
    logic        is_exit_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    br_eval u_dut (
        .clk(clk), .rst(rst), .opcode_i(opcode_i), .src_sel_i(src_sel_i),
        .dst_val_i(dst_val_i), .src_val_i(src_val_i), .imm_i(imm_i),
        .offset_i(offset_i), .pc_i(pc_i), .taken_o(taken_o), .next_pc_o(next_pc_o),
        .is_call_o(is_call_o), .is_exit_o(is_exit_o), .illegal_o(illegal_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    typedef struct {
        bit          tk;
        logic [31:0] np;
        bit          ic;
        bit          ie;
        bit          il;
    } exp_t;

    function automatic exp_t ref_eval(logic [7:0] op, logic [3:0] sf, logic [63:0] d,
                                      logic [63:0] s, logic [31:0] imm, logic [15:0] off,
                                      logic [31:0] pc);
        exp_t e;
        int cls = int'(op[2:0]);
        int code = int'(op[7:4]);
        bit w = (cls == 5);
        logic [63:0] sv;
        longint unsigned a, b;
        longint sa, sb;
        int off_i;
        e.tk = 0; e.ic = 0; e.ie = 0; e.il = 1;
        sv = op[3] ? s : {{32{imm[31]}}, imm};
        if (w) begin
            a = d; b = sv; sa = $signed(d); sb = $signed(sv);
        end else begin
            a = {32'd0, d[31:0]}; b = {32'd0, sv[31:0]};
            sa = $signed(d[31:0]); sb = $signed(sv[31:0]);
        end
        if (cls == 5 || cls == 6) begin
            e.il = 0;
            case (code)
                0:  if (w) e.tk = 1; else e.il = 1;
                1:  e.tk = (a == b);
                2:  e.tk = (a > b);
                3:  e.tk = (a >= b);
                4:  e.tk = ((a & b) != 0);
                5:  e.tk = (a != b);
                6:  e.tk = (sa > sb);
                7:  e.tk = (sa >= sb);
                8:  if (w && sf <= 2) begin e.ic = 1; e.tk = (sf == 1); end else e.il = 1;
                9:  if (w) e.ie = 1; else e.il = 1;
                10: e.tk = (a < b);
                11: e.tk = (a <= b);
                12: e.tk = (sa < sb);
                13: e.tk = (sa <= sb);
                default: e.il = 1;
            endcase
        end
        off_i = $signed(off);
        e.np = e.tk ? pc + 32'd1 + 32'(off_i) : pc + 32'd1;
        return e;
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag, exp_t e);
        check_bit(tag, "taken", taken_o, e.tk);
        check_bit(tag, "is_call", is_call_o, e.ic);
        check_bit(tag, "is_exit", is_exit_o, e.ie);
        check_bit(tag, "illegal", illegal_o, e.il);
        checks++;
        if (next_pc_o !== e.np) begin
            fails++;
            $display("FAIL %s next_pc: actual=%h expected=%h", tag, next_pc_o, e.np);
        end
    endtask

    // Drive on a falling edge, cross one rising edge, compare on the next falling edge
    task automatic apply(string tag, logic [7:0] op, logic [3:0] sf, logic [63:0] d,
                         logic [63:0] s, logic [31:0] imm, logic [15:0] off, logic [31:0] pc);
        exp_t e;
        opcode_i = op; src_sel_i = sf; dst_val_i = d; src_val_i = s;
        imm_i = imm; offset_i = off; pc_i = pc;
        e = ref_eval(op, sf, d, s, imm, off, pc);
        @(negedge clk);
        check_all(tag, e);
    endtask

    function automatic string tag_of(logic [7:0] op);
        int code = int'(op[7:4]);
        if (op[2:0] != 3'd5 && op[2:0] != 3'd6) return "R10";
        case (code)
            0: return "R7";
            1, 4, 5: return "R5";
            2, 3, 10, 11: return "R3";
            6, 7, 12, 13: return "R4";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        exp_t z;
        z.tk = 0; z.np = 0; z.ic = 0; z.ie = 0; z.il = 0;
        rst = 1'b1;
        opcode_i = 8'h15; pc_i = 32'd77;
        repeat (3) @(negedge clk);
        check_all("R11", z);
        rst = 1'b0;

        // R1: upper halves differ, low halves equal
        apply("R1", 8'h1d, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 0, 16'd4, 32'd20);
        apply("R1", 8'h1e, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 0, 16'd4, 32'd20);
        // R11: output still holds the previous result before the next rising edge
        opcode_i = 8'h95; pc_i = 32'd500;
        #1;
        check_bit("R11", "held taken", taken_o, 1'b1);
        // R2: immediate is sign-extended for the wide compare
        apply("R2", 8'h15, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd2, 32'd8);
        apply("R2", 8'h1d, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 32'hFFFF_FFFF, 16'd2, 32'd8);
        // R4: 0x7e is narrow signed >= against a register: -1 >= 1 is false
        apply("R4", 8'h7e, 0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 16'd3, 32'd40);
        // R3: the same operands as unsigned >= are taken
        apply("R3", 8'h3e, 0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 16'd3, 32'd40);
        apply("R3", 8'hbd, 0, 64'd5, 64'd5, 0, 16'd1, 32'd1);
        apply("R4", 8'hcd, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd1, 32'd1);
        // R5: bit test
        apply("R5", 8'h45, 0, 64'h0100_0000_0000_0000, 0, 32'h0000_0001, 16'd9, 32'd2);
        apply("R5", 8'h4d, 0, 64'h0100_0000_0000_0000, 64'h0100_0000_0000_0000, 0, 16'd9, 32'd2);
        // R6: negative offset and wrap
        apply("R6", 8'h05, 0, 0, 0, 0, 16'hFFFB, 32'd10);
        apply("R6", 8'h05, 0, 0, 0, 0, 16'hFFFE, 32'd0);
        apply("R6", 8'h55, 0, 1, 1, 0, 16'd100, 32'hFFFF_FFFF);
        // R7: unconditional jump ignores operands
        apply("R7", 8'h05, 0, 64'd1, 64'd2, 32'd3, 16'd6, 32'd30);
        // R8: call kinds
        apply("R8", 8'h85, 4'd1, 0, 0, 0, 16'd12, 32'd50);
        apply("R8", 8'h85, 4'd0, 0, 0, 32'd7, 16'd12, 32'd50);
        apply("R8", 8'h85, 4'd2, 0, 0, 32'd7, 16'd12, 32'd50);
        apply("R8", 8'h85, 4'd3, 0, 0, 0, 16'd12, 32'd50);
        // R9: return
        apply("R9", 8'h95, 0, 0, 0, 0, 16'd7, 32'd60);
        // R10: narrow class restrictions, reserved codes, other classes
        apply("R10", 8'h06, 0, 0, 0, 0, 16'd7, 32'd61);
        apply("R10", 8'h96, 0, 0, 0, 0, 16'd7, 32'd62);
        apply("R10", 8'h86, 4'd1, 0, 0, 0, 16'd7, 32'd63);
        apply("R10", 8'he5, 0, 0, 0, 0, 16'd7, 32'd64);
        apply("R10", 8'h07, 0, 0, 0, 0, 16'd7, 32'd65);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            logic [2:0] cls;
            logic [63:0] d, s;
            case ($urandom_range(0, 4))
                0, 1: cls = 3'd5;
                2, 3: cls = 3'd6;
                default: cls = 3'($urandom_range(0, 7));
            endcase
            op = {4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), cls};
            d = {$urandom, $urandom};
            s = ($urandom_range(0, 3) == 0) ? d : {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) s[31:0] = d[31:0];
            apply(tag_of(op), op, 4'($urandom_range(0, 3)), d, s, $urandom,
                  16'($urandom), $urandom);
        end

        // R11: reset in the middle of traffic clears outputs
        opcode_i = 8'h05; rst = 1'b1;
        @(negedge clk);
        check_all("R11", z);
        rst = 1'b0;

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule